// File: doc/BRIEF.md
# Rotating-Window Register File with Trap Entry

This block holds the integer registers of a 32-bit core whose register space is organised as overlapping windows on a ring. Software sees 32 architectural register numbers split into four groups of eight: numbers 0-7 are globals shared by every window, 8-15 are the outs, 16-23 are the locals and 24-31 are the ins. A current window pointer selects which physical registers the windowed groups reach. The outs of window `w` are the same physical registers as the ins of window `w-1` (modulo the window count), so a value a caller leaves in its outs is what the callee finds in its ins after a save. Two combinational read ports and one write port all remap through the pointer, and a write to the register being read in the same cycle is forwarded to the read.

Save moves the pointer down one window and restore moves it up one, each refused when the target window's bit in a window-invalid mask is set; a refusal raises a one-cycle overflow or underflow flag. A trap request, accepted only while traps are enabled, starts a four-state sequencer. In `ST_IDLE` the request (`IDLE->SPILL_PC`) clears the trap-enable bit, copies the supervisor bit into the previous-supervisor bit, enters supervisor mode and moves the pointer down one window without consulting the mask. The states `ST_SPILL_PC`, `ST_SPILL_NPC` and `ST_SPILL_STAT` then write the captured program counter, next program counter and pre-trap status word into locals 0, 1 and 2 of the new window, one per cycle (`SPILL_PC->SPILL_NPC->SPILL_STAT->IDLE`). The mask and the mode bits can be written only from supervisor mode.

Top module: `wrf_regfile`

## Requirements
- R1: Register numbers 0-7 reach the same globals in every window; 16-23 reach locals private to the current window, so a local written in one window is not seen from another.
- R2: Register 0 always reads as zero on both read ports; writes to it are discarded.
- R3: Out register 8+k of window w and in register 24+k of window w-1 (mod window count) are one physical register: a value written to an out before a save is read from the matching in after it.
- R4: In `ST_IDLE`, an accepted save sets the pointer to pointer-1 and an accepted restore to pointer+1, both modulo the window count, visible the cycle after the request; trap beats save, save beats restore; pointer resets to 0.
- R5: A save (restore) whose target window has its mask bit set leaves the pointer unchanged and raises `win_overflow` (`win_underflow`) for exactly the cycle after the request; the two flags are never high together.
- R6: A trap request while `trap_enable`=1 in `ST_IDLE` makes, the next cycle, `trap_enable`=0, `prev_supervisor`=old `supervisor`, `supervisor`=1 and pointer=pointer-1 regardless of the mask; with `trap_enable`=0 the request is ignored.
- R7: After trap entry the sequencer steps `ST_SPILL_PC`, `ST_SPILL_NPC`, `ST_SPILL_STAT`, one cycle each with `busy`=1, writing `trap_pc`, `trap_npc` and the pre-trap status word to registers 16, 17, 18 of the new window; while `busy`=1 the external write port, save, restore, trap and mode writes are ignored.
- R8: `status_word` has the pointer in bits [log2(windows)-1:0], `supervisor` in bit 5, `prev_supervisor` in bit 6, `trap_enable` in bit 7 and zero elsewhere.
- R9: `wim_wr_en` loads the mask only while `supervisor`=1; in user mode the mask is unchanged.
- R10: `mode_wr_en` loads `supervisor` and `trap_enable` from `mode_wr_sup` and `mode_wr_et` only while `supervisor`=1 and the sequencer is idle and no trap is accepted that cycle.
- R11: A read of the physical register being written in the same cycle returns the new data.
- R12: After reset the pointer is 0, `supervisor`=1, `prev_supervisor`=0, `trap_enable`=1, the mask is all zero and `busy`, `win_overflow`, `win_underflow` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Register number, read port A |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Register number, read port B |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move pointer down one window |
| restore_req | input | 1 | Move pointer up one window |
| trap_req | input | 1 | Start trap entry |
| trap_pc | input | XLEN | Program counter to spill on trap |
| trap_npc | input | XLEN | Next program counter to spill on trap |
| wim_wr_en | input | 1 | Mask write enable (supervisor only) |
| wim_wr_data | input | NWIN | New mask value |
| mode_wr_en | input | 1 | Mode write enable (supervisor only) |
| mode_wr_sup | input | 1 | New supervisor bit |
| mode_wr_et | input | 1 | New trap-enable bit |
| cwp | output | CW | Current window pointer |
| wim | output | NWIN | Window-invalid mask |
| supervisor | output | 1 | Supervisor mode |
| prev_supervisor | output | 1 | Supervisor bit before the last trap |
| trap_enable | output | 1 | Traps accepted |
| status_word | output | XLEN | Packed status (R8) |
| win_overflow | output | 1 | Save refused by mask |
| win_underflow | output | 1 | Restore refused by mask |
| busy | output | 1 | Trap spill in progress |

## Verification
The assertions assume every request input is a known value at each rising edge and is held for whole cycles, and that the window count is a power of two not above 32 with XLEN of at least 8. They also take as given that a caller does not rely on requests issued while `busy` is high, which the block drops by design. The stimulus drives all inputs one time unit after a rising edge, samples registered outputs at the same point and combinational reads before the next edge, so no request straddles an edge and every register value read back was written earlier by the bench or by the spill sequence.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPILL_PC,
        ST_SPILL_NPC,
        ST_SPILL_STAT
    } wrf_state_e;

    localparam int STB_SUP  = 5;
    localparam int STB_PSUP = 6;
    localparam int STB_ET   = 7;

    localparam logic [4:0] LOCAL_PC   = 5'd16;
    localparam logic [4:0] LOCAL_NPC  = 5'd17;
    localparam logic [4:0] LOCAL_STAT = 5'd18;
endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter int PW   = 8
) (
    input  logic [4:0]    arch_idx,
    input  logic [CW-1:0] win,
    output logic [PW-1:0] phys_idx
);
    logic [CW-1:0] win_below;
    assign win_below = (win == '0) ? CW'(NWIN - 1) : win - 1'b1;

    always_comb begin
        int k;
        int v;
        k = int'(arch_idx[2:0]);
        unique case (arch_idx[4:3])
            2'd0: v = k;
            2'd1: v = 8 + int'(win_below) * 16 + k;
            2'd2: v = 8 + int'(win) * 16 + 8 + k;
            default: v = 8 + int'(win) * 16 + k;
        endcase
        phys_idx = PW'(v);
    end
endmodule

// File: rtl/wrf_ctl.sv
module wrf_ctl import wrf_pkg::*; #(
    parameter int NWIN = 8,
    parameter int XLEN = 32,
    parameter int CW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] trap_npc,
    input  logic            wim_wr_en,
    input  logic [NWIN-1:0] wim_wr_data,
    input  logic            mode_wr_en,
    input  logic            mode_wr_sup,
    input  logic            mode_wr_et,
    output logic [CW-1:0]   cwp,
    output logic [NWIN-1:0] wim,
    output logic            supervisor,
    output logic            prev_supervisor,
    output logic            trap_enable,
    output logic [XLEN-1:0] status_word,
    output logic            win_overflow,
    output logic            win_underflow,
    output logic            busy,
    output logic            spill_en,
    output logic [4:0]      spill_idx,
    output logic [XLEN-1:0] spill_data
);
    wrf_state_e st_q, st_d;
    logic [CW-1:0]   cwp_q, cwp_m1, cwp_p1;
    logic [NWIN-1:0] wim_q;
    logic            sup_q, psup_q, et_q, ovf_q, unf_q;
    logic [XLEN-1:0] pc_q, npc_q, stat_q, stat_now;
    logic            idle, trap_go, save_go, rest_go, mode_go;

    assign cwp_m1 = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - 1'b1;
    assign cwp_p1 = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + 1'b1;

    assign idle    = (st_q == ST_IDLE);
    assign trap_go = idle && trap_req && et_q;
    assign save_go = idle && !trap_go && save_req;
    assign rest_go = idle && !trap_go && !save_req && restore_req;
    assign mode_go = idle && !trap_go && mode_wr_en && sup_q;

    always_comb begin
        stat_now              = '0;
        stat_now[CW-1:0]      = cwp_q;
        stat_now[STB_SUP]     = sup_q;
        stat_now[STB_PSUP]    = psup_q;
        stat_now[STB_ET]      = et_q;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       if (trap_go) st_d = ST_SPILL_PC;
            ST_SPILL_PC:   st_d = ST_SPILL_NPC;
            ST_SPILL_NPC:  st_d = ST_SPILL_STAT;
            ST_SPILL_STAT: st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // window pointer, mode bits, mask and trap capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cwp_q  <= '0;
            wim_q  <= '0;
            sup_q  <= 1'b1;
            psup_q <= 1'b0;
            et_q   <= 1'b1;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
            pc_q   <= '0;
            npc_q  <= '0;
            stat_q <= '0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            if (trap_go) begin
                pc_q   <= trap_pc;
                npc_q  <= trap_npc;
                stat_q <= stat_now;
                cwp_q  <= cwp_m1;
                et_q   <= 1'b0;
                psup_q <= sup_q;
                sup_q  <= 1'b1;
            end else begin
                if (save_go) begin
                    if (wim_q[cwp_m1]) ovf_q <= 1'b1;
                    else               cwp_q <= cwp_m1;
                end else if (rest_go) begin
                    if (wim_q[cwp_p1]) unf_q <= 1'b1;
                    else               cwp_q <= cwp_p1;
                end
                if (mode_go) begin
                    sup_q <= mode_wr_sup;
                    et_q  <= mode_wr_et;
                end
            end
            if (wim_wr_en && sup_q) wim_q <= wim_wr_data;
        end
    end

    // spill outputs
    always_comb begin
        spill_en   = 1'b0;
        spill_idx  = LOCAL_PC;
        spill_data = pc_q;
        unique case (st_q)
            ST_SPILL_PC:   begin spill_en = 1'b1; spill_idx = LOCAL_PC;   spill_data = pc_q;   end
            ST_SPILL_NPC:  begin spill_en = 1'b1; spill_idx = LOCAL_NPC;  spill_data = npc_q;  end
            ST_SPILL_STAT: begin spill_en = 1'b1; spill_idx = LOCAL_STAT; spill_data = stat_q; end
            default:       spill_en = 1'b0;
        endcase
    end

    assign cwp             = cwp_q;
    assign wim             = wim_q;
    assign supervisor      = sup_q;
    assign prev_supervisor = psup_q;
    assign trap_enable     = et_q;
    assign status_word     = stat_now;
    assign win_overflow    = ovf_q;
    assign win_underflow   = unf_q;
    assign busy            = !idle;

    assert_save_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && save_req && !(trap_req && et_q) && !wim_q[cwp_m1]) |=> (cwp_q == $past(cwp_m1)));

    assert_refused_keeps_cwp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q || unf_q) |-> (cwp_q == $past(cwp_q)));

    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_q, unf_q}));

    assert_trap_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && trap_req && et_q) |=>
            (!et_q && sup_q && (psup_q == $past(sup_q)) && (cwp_q == $past(cwp_m1))));

    assert_spill_pc_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SPILL_PC) |=> (st_q == ST_SPILL_NPC));

    assert_spill_npc_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SPILL_NPC) |=> (st_q == ST_SPILL_STAT));

    assert_wim_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wim_wr_en && !sup_q) |=> $stable(wim_q));
endmodule

// File: rtl/wrf_regfile.sv
module wrf_regfile import wrf_pkg::*; #(
    parameter  int NWIN = 8,
    parameter  int XLEN = 32,
    localparam int CW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [4:0]      rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            trap_req,
    input  logic [XLEN-1:0] trap_pc,
    input  logic [XLEN-1:0] trap_npc,
    input  logic            wim_wr_en,
    input  logic [NWIN-1:0] wim_wr_data,
    input  logic            mode_wr_en,
    input  logic            mode_wr_sup,
    input  logic            mode_wr_et,
    output logic [CW-1:0]   cwp,
    output logic [NWIN-1:0] wim,
    output logic            supervisor,
    output logic            prev_supervisor,
    output logic            trap_enable,
    output logic [XLEN-1:0] status_word,
    output logic            win_overflow,
    output logic            win_underflow,
    output logic            busy
);
    localparam int NPHYS = 8 + NWIN * 16;
    localparam int PW    = $clog2(NPHYS);
    localparam int NPORT = 3;

    logic            spill_en;
    logic [4:0]      spill_idx;
    logic [XLEN-1:0] spill_data;
    logic            w_en;
    logic [4:0]      w_idx;
    logic [XLEN-1:0] w_data;
    logic            w_fire;
    logic [4:0]      map_idx  [NPORT];
    logic [PW-1:0]   map_phys [NPORT];
    logic [XLEN-1:0] mem [NPHYS];

    wrf_ctl #(.NWIN(NWIN), .XLEN(XLEN), .CW(CW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .save_req(save_req), .restore_req(restore_req), .trap_req(trap_req),
        .trap_pc(trap_pc), .trap_npc(trap_npc),
        .wim_wr_en(wim_wr_en), .wim_wr_data(wim_wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_sup(mode_wr_sup), .mode_wr_et(mode_wr_et),
        .cwp(cwp), .wim(wim), .supervisor(supervisor),
        .prev_supervisor(prev_supervisor), .trap_enable(trap_enable),
        .status_word(status_word), .win_overflow(win_overflow),
        .win_underflow(win_underflow), .busy(busy),
        .spill_en(spill_en), .spill_idx(spill_idx), .spill_data(spill_data)
    );

    // spill sequencer owns the write port while busy
    assign w_en   = busy ? spill_en   : wr_en;
    assign w_idx  = busy ? spill_idx  : wr_idx;
    assign w_data = busy ? spill_data : wr_data;

    assign map_idx[0] = rd_a_idx;
    assign map_idx[1] = rd_b_idx;
    assign map_idx[2] = w_idx;

    for (genvar gp = 0; gp < NPORT; gp++) begin : g_map
        wrf_map #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_map (
            .arch_idx(map_idx[gp]),
            .win(cwp),
            .phys_idx(map_phys[gp])
        );
    end

    assign w_fire = w_en && (map_phys[2] != '0);

    always_ff @(posedge clk) begin
        if (w_fire) mem[map_phys[2]] <= w_data;
    end

    always_comb begin
        if (map_phys[0] == '0)                 rd_a_data = '0;
        else if (w_fire && map_phys[2] == map_phys[0]) rd_a_data = w_data;
        else                                   rd_a_data = mem[map_phys[0]];
        if (map_phys[1] == '0)                 rd_b_data = '0;
        else if (w_fire && map_phys[2] == map_phys[1]) rd_b_data = w_data;
        else                                   rd_b_data = mem[map_phys[1]];
    end

    assert_g0_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    assert_spill_uses_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spill_en |-> (spill_idx[4:3] == 2'd2));
endmodule

// File: tb/sim_wrf_regfile.sv
module sim_wrf_regfile;
    localparam int CLK_P = 10;
    localparam int NWIN  = 8;
    localparam int XLEN  = 32;
    localparam int NVEC  = 8;

    // row: wr_en[74] wr_idx[73:69] wr_data[68:37] rd_idx[36:32] exp[31:0]
    localparam logic [74:0] VEC [NVEC] = '{
        {1'b1, 5'd1,  32'h11111111, 5'd0,  32'h00000000},  // R2 g0 read
        {1'b1, 5'd0,  32'hDEADBEEF, 5'd1,  32'h11111111},  // R1 global kept, write g0
        {1'b0, 5'd0,  32'h0,        5'd0,  32'h00000000},  // R2 g0 write dropped
        {1'b1, 5'd16, 32'hA0A0A0A0, 5'd16, 32'hA0A0A0A0},  // R11 bypass
        {1'b1, 5'd10, 32'h0B0B0B0B, 5'd16, 32'hA0A0A0A0},  // R1 local held
        {1'b1, 5'd24, 32'h24242424, 5'd10, 32'h0B0B0B0B},  // R1 out held
        {1'b1, 5'd7,  32'h00000077, 5'd24, 32'h24242424},  // R1 in held
        {1'b0, 5'd0,  32'h0,        5'd7,  32'h00000077}   // R1 global 7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [XLEN-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic wr_en = 0, save_req = 0, restore_req = 0, trap_req = 0;
    logic [XLEN-1:0] trap_pc = '0, trap_npc = '0;
    logic wim_wr_en = 0;
    logic [NWIN-1:0] wim_wr_data = '0;
    logic mode_wr_en = 0, mode_wr_sup = 0, mode_wr_et = 0;
    logic [2:0] cwp;
    logic [NWIN-1:0] wim;
    logic supervisor, prev_supervisor, trap_enable, win_overflow, win_underflow, busy;
    logic [XLEN-1:0] status_word;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    wrf_regfile #(.NWIN(NWIN), .XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req), .trap_req(trap_req),
        .trap_pc(trap_pc), .trap_npc(trap_npc),
        .wim_wr_en(wim_wr_en), .wim_wr_data(wim_wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_sup(mode_wr_sup), .mode_wr_et(mode_wr_et),
        .cwp(cwp), .wim(wim), .supervisor(supervisor),
        .prev_supervisor(prev_supervisor), .trap_enable(trap_enable),
        .status_word(status_word), .win_overflow(win_overflow),
        .win_underflow(win_underflow), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic read_a(input logic [4:0] idx);
        rd_a_idx = idx;
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R12 reset state
        chk("R12 cwp", 32'(cwp), 0);
        chk("R12 sup/psup/et", {29'b0, supervisor, prev_supervisor, trap_enable}, 32'b101);
        chk("R12 wim/busy/flags", {20'b0, wim, busy, win_overflow, win_underflow}, 0);
        chk("R8 reset status", status_word, 32'hA0);

        // table: R1 R2 R11
        for (int i = 0; i < NVEC; i++) begin
            wr_en    = VEC[i][74];
            wr_idx   = VEC[i][73:69];
            wr_data  = VEC[i][68:37];
            rd_a_idx = VEC[i][36:32];
            rd_b_idx = VEC[i][36:32];
            #1;
            chk($sformatf("R1/R2/R11 vec%0d port A", i), rd_a_data, VEC[i][31:0]);
            chk($sformatf("R1/R2/R11 vec%0d port B", i), rd_b_data, VEC[i][31:0]);
            tick();
        end
        wr_en = 0;

        // R3 overlap and R4 save
        save_req = 1; tick(); save_req = 0;
        chk("R4 save to 7", 32'(cwp), 7);
        read_a(5'd26); chk("R3 out2 seen as in2", rd_a_data, 32'h0B0B0B0B);
        read_a(5'd1);  chk("R1 global across window", rd_a_data, 32'h11111111);
        wr_en = 1; wr_idx = 5'd16; wr_data = 32'h55555555; tick(); wr_en = 0;
        restore_req = 1; tick(); restore_req = 0;
        chk("R4 restore to 0", 32'(cwp), 0);
        read_a(5'd16); chk("R1 local private", rd_a_data, 32'hA0A0A0A0);

        // R5 mask refusal
        wim_wr_en = 1; wim_wr_data = 8'h82; tick(); wim_wr_en = 0;
        chk("R9 wim write in supervisor", 32'(wim), 32'h82);
        save_req = 1; tick(); save_req = 0;
        chk("R5 overflow flag", {30'b0, win_overflow, win_underflow}, 32'b10);
        chk("R5 cwp kept on overflow", 32'(cwp), 0);
        tick();
        chk("R5 overflow one cycle", 32'(win_overflow), 0);
        restore_req = 1; tick(); restore_req = 0;
        chk("R5 underflow flag", {30'b0, win_overflow, win_underflow}, 32'b01);
        chk("R5 cwp kept on underflow", 32'(cwp), 0);
        wim_wr_en = 1; wim_wr_data = 8'h00; tick(); wim_wr_en = 0;

        // R6 R7 trap entry and spill
        trap_req = 1; trap_pc = 32'h00000100; trap_npc = 32'h00000104;
        tick(); trap_req = 0;
        chk("R6 cwp dec", 32'(cwp), 7);
        chk("R6 sup/psup/et", {29'b0, supervisor, prev_supervisor, trap_enable}, 32'b110);
        chk("R7 busy entry", 32'(busy), 1);
        save_req = 1; wr_en = 1; wr_idx = 5'd16; wr_data = 32'hBAD0BAD0;
        tick(); chk("R7 busy spill 2", 32'(busy), 1);
        tick(); chk("R7 busy spill 3", 32'(busy), 1);
        tick(); chk("R7 idle after spill", 32'(busy), 0);
        save_req = 0; wr_en = 0;
        chk("R7 save ignored while busy", 32'(cwp), 7);
        read_a(5'd16); chk("R7 l0 = pc", rd_a_data, 32'h100);
        read_a(5'd17); chk("R7 l1 = npc", rd_a_data, 32'h104);
        read_a(5'd18); chk("R7 l2 = status", rd_a_data, 32'hA0);

        // R6 trap ignored with traps disabled
        trap_req = 1; tick(); trap_req = 0;
        chk("R6 trap ignored when disabled", {27'b0, busy, 1'b0, cwp}, 32'h7);

        // R10 mode write, R8 layout
        mode_wr_en = 1; mode_wr_sup = 0; mode_wr_et = 1; tick(); mode_wr_en = 0;
        chk("R10 mode write", {30'b0, supervisor, trap_enable}, 32'b01);
        chk("R8 status layout", status_word, 32'hC7);
        wim_wr_en = 1; wim_wr_data = 8'hFF; tick(); wim_wr_en = 0;
        chk("R9 wim write ignored in user", 32'(wim), 0);
        mode_wr_en = 1; mode_wr_sup = 1; mode_wr_et = 0; tick(); mode_wr_en = 0;
        chk("R10 mode write ignored in user", {30'b0, supervisor, trap_enable}, 32'b01);

        // trap from user mode
        trap_req = 1; trap_pc = 32'h00000200; trap_npc = 32'h00000204;
        tick(); trap_req = 0;
        chk("R6 user trap", {26'b0, supervisor, prev_supervisor, trap_enable, cwp}, {26'b0, 3'b100, 3'd6});
        repeat (3) tick();
        read_a(5'd18); chk("R7 user status spilled", rd_a_data, 32'hC7);
        read_a(5'd16); chk("R7 user pc spilled", rd_a_data, 32'h200);

        // R4 priority: save beats restore
        save_req = 1; restore_req = 1; tick(); save_req = 0; restore_req = 0;
        chk("R4 save beats restore", 32'(cwp), 5);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule